// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block decides which operating mode a low-power radio transceiver is in. It watches three control pins from the host: a reset that is active low, a run enable that is active high, and a wake request that is active low. It also reads three values set by the register file: the choice between a receive and a transmit sequence, a request to enter a low-power state, and the choice between the light (doze) and deep (hibernate) low-power state. A single-cycle done pulse stands in for the end of a receive or transmit sequence. The block reports the current mode as a 3-bit code and raises an out-of-idle flag.

The mode follows both edges and levels of the pins. A rising edge on run enable starts a sequence, and the sequence runs only while run enable stays high. Once a sequence has ended, the host must drop run enable before it can start another one. The wake pin brings the device out of either low-power state. Both asynchronous pins pass through a two-flop synchronizer before their edges are detected. The other inputs are synchronous to the block clock.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mode` becomes 0 (Off) and `out_of_idle` becomes 1, whatever the other inputs do.
- R2: On the first clock edge after `rst_n` goes high, `mode` moves from Off to 1 (Idle).
- R3: In Idle, a low-to-high change on `run_en` moves `mode` to 4 (receive) if `seq_sel` is 0, or to 5 (transmit) if `seq_sel` is 1. The new mode appears on the third clock edge after the pin changes.
- R4: In receive or transmit, `run_en` low returns `mode` to Idle on the third clock edge after the pin falls.
- R5: `seq_done` high in receive or transmit returns `mode` to Idle on that clock edge. No new sequence starts while `run_en` stays high; a later fall and rise of `run_en` starts one.
- R6: `lp_req` high in Idle moves `mode` to 2 (Doze) if `lp_sel` is 0, or to 3 (Hibernate) if `lp_sel` is 1, on that edge. `lp_req` in any other mode has no effect.
- R7: A rising edge on `run_en` while in Doze or Hibernate is ignored: the mode stays the same. After a later wake, no sequence starts while `run_en` stays high.
- R8: A high-to-low change on `attn_n` in Doze or Hibernate returns `mode` to Idle on the third clock edge after the pin falls. In Idle, receive or transmit it has no effect.
- R9: `out_of_idle` is 1 exactly when `mode` is not Idle, and is updated on the same edge as `mode`.
- R10: When a `run_en` rising edge and `lp_req` reach Idle on the same edge, the sequence start wins over the low-power request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Reset pin, active low, sampled synchronously |
| run_en | input | 1 | Asynchronous sequence enable pin, active high |
| attn_n | input | 1 | Asynchronous wake pin, active low |
| seq_sel | input | 1 | Sequence choice: 0 receive, 1 transmit |
| lp_req | input | 1 | Low-power entry request, one cycle |
| lp_sel | input | 1 | Low-power choice: 0 doze, 1 hibernate |
| seq_done | input | 1 | End of the running sequence, one cycle |
| mode | output | 3 | Current mode: 0 Off, 1 Idle, 2 Doze, 3 Hibernate, 4 receive, 5 transmit |
| out_of_idle | output | 1 | High whenever the mode is not Idle |

## Verification
Results from the synchronous inputs (`seq_done`, `lp_req`, and reset release) are due on the first clock edge after the input is driven. Results from the pins `run_en` and `attn_n` are due on the third edge, because the path holds two synchronizer flops and then the mode register. The bench drives every input on the falling clock edge and samples on a later falling edge. For each stimulus it waits at least the due number of rising edges before it compares. The directed timing cases sample one edge early as well, to show that the pin paths are not fast.

// File: rtl/xcvr_mode_pkg.sv
// Package: shared mode encoding for the transceiver operating mode controller.
// Assumes: consumers only need the 3-bit code; values 6 and 7 are unused.
package xcvr_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 3'd0,
        MODE_IDLE = 3'd1,
        MODE_DOZE = 3'd2,
        MODE_HIB  = 3'd3,
        MODE_RX   = 3'd4,
        MODE_TX   = 3'd5
    } mode_e;

    // True for the two modes in which a sequence is running.
    function automatic logic is_seq(input mode_e m);
        return (m == MODE_RX) || (m == MODE_TX);
    endfunction

    // True for the two low-power modes.
    function automatic logic is_low_power(input mode_e m);
        return (m == MODE_DOZE) || (m == MODE_HIB);
    endfunction

endpackage

// File: rtl/xcvr_mode_sync.sv
// Module: multi-flop level synchronizer for WIDTH asynchronous inputs.
// Assumes: each bit changes slowly compared to clk; RST_VAL is the value
// that represents the inactive state of each bit.
module xcvr_mode_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
    end

    // Later stages settle out metastability, one flop each.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/xcvr_mode_edge.sv
// Module: rise and fall detector on an already synchronized level.
// Assumes: lvl_i is synchronous to clk; RST_VAL equals the level's own reset
// value, so no edge is reported right after reset.
module xcvr_mode_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Keep the previous cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/xcvr_mode_fsm.sv
// Module: operating-mode state machine.
// Assumes: en_lvl, en_rise and attn_fall are synchronized and edge-detected
// upstream; seq_sel, lp_req, lp_sel and seq_done are synchronous to clk.
// Priority in Idle: sequence start over low-power entry.
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_lvl,
    input  logic              en_rise,
    input  logic              attn_fall,
    input  logic              seq_sel,
    input  logic              lp_req,
    input  logic              lp_sel,
    input  logic              seq_done,
    output logic [MODE_W-1:0] mode_o,
    output logic              busy_o
);

    mode_e mode_q;
    mode_e mode_nxt;
    logic  busy_q;

    // Next-mode decision from the current mode and the qualified inputs.
    always_comb begin
        mode_nxt = mode_q;
        case (mode_q)
            MODE_OFF: mode_nxt = MODE_IDLE;
            MODE_IDLE: begin
                if (en_rise)     mode_nxt = seq_sel ? MODE_TX : MODE_RX;
                else if (lp_req) mode_nxt = lp_sel ? MODE_HIB : MODE_DOZE;
            end
            MODE_DOZE, MODE_HIB: begin
                if (attn_fall) mode_nxt = MODE_IDLE;
            end
            MODE_RX, MODE_TX: begin
                if (!en_lvl || seq_done) mode_nxt = MODE_IDLE;
            end
            default: mode_nxt = MODE_IDLE;
        endcase
    end

    // Mode register; reset holds the block in Off.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_nxt;
    end

    // Registered out-of-idle flag, kept aligned with the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b1;
        else        busy_q <= (mode_nxt != MODE_IDLE);
    end

    assign mode_o = mode_q;
    assign busy_o = busy_q;

endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Module: top of the transceiver operating mode controller.
// Assumes: run_en and attn_n are asynchronous pins; all other inputs are
// synchronous to clk; rst_n is sampled on clk.
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              attn_n,
    input  logic              seq_sel,
    input  logic              lp_req,
    input  logic              lp_sel,
    input  logic              seq_done,
    output logic [MODE_W-1:0] mode,
    output logic              out_of_idle
);

    localparam int SYNC_DEPTH = 2;

    logic en_s;
    logic attn_n_s;
    logic en_rise;
    logic en_fall_unused;
    logic attn_rise_unused;
    logic attn_fall;

    // Synchronizers: enable idles low, wake idles high.
    xcvr_mode_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .async_i(run_en), .sync_o(en_s)
    );
    xcvr_mode_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_attn (
        .clk(clk), .rst_n(rst_n), .async_i(attn_n), .sync_o(attn_n_s)
    );

    // Edge detectors on the synchronized levels.
    xcvr_mode_edge #(.RST_VAL(1'b0)) u_edge_en (
        .clk(clk), .rst_n(rst_n), .lvl_i(en_s),
        .rise_o(en_rise), .fall_o(en_fall_unused)
    );
    xcvr_mode_edge #(.RST_VAL(1'b1)) u_edge_attn (
        .clk(clk), .rst_n(rst_n), .lvl_i(attn_n_s),
        .rise_o(attn_rise_unused), .fall_o(attn_fall)
    );

    xcvr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_lvl   (en_s),
        .en_rise  (en_rise),
        .attn_fall(attn_fall),
        .seq_sel  (seq_sel),
        .lp_req   (lp_req),
        .lp_sel   (lp_sel),
        .seq_done (seq_done),
        .mode_o   (mode),
        .busy_o   (out_of_idle)
    );

endmodule

// File: rtl/xcvr_mode_chk.sv
// Module: property checker bound to xcvr_mode_ctrl; observes ports only.
// Assumes: the two-flop synchronizer depth of the top (pin-to-mode latency 3).
module xcvr_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       attn_n,
    input logic       seq_sel,
    input logic       lp_req,
    input logic [2:0] mode,
    input logic       out_of_idle
);

    logic [2:0] live_cnt;

    // Counts edges since reset release, saturating, to bound $past windows.
    always_ff @(posedge clk) begin
        if (!rst_n)              live_cnt <= '0;
        else if (live_cnt != 3'd7) live_cnt <= live_cnt + 3'd1;
    end

    p_off_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == 3'd0 && out_of_idle));

    p_off_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> (mode == 3'd1));

    p_seq_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd1 && (mode == 3'd4 || mode == 3'd5) && $past(mode) == 3'd1)
        |-> (mode == ($past(seq_sel) ? 3'd5 : 3'd4)));

    p_seq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd4 && (mode == 3'd4 || mode == 3'd5)) |-> $past(run_en, 3));

    p_lp_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd1 && (mode == 3'd2 || mode == 3'd3) && $past(mode) != mode)
        |-> ($past(mode) == 3'd1 && $past(lp_req)));

    p_wake_needs_attn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd4 && mode == 3'd1 && ($past(mode) == 3'd2 || $past(mode) == 3'd3))
        |-> !$past(attn_n, 3));

    p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_idle == (mode != 3'd1));

endmodule

bind xcvr_mode_ctrl xcvr_mode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .attn_n(attn_n),
    .seq_sel(seq_sel), .lp_req(lp_req), .mode(mode), .out_of_idle(out_of_idle)
);

// File: tb/tb_xcvr_mode_ctrl.sv
module tb_xcvr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       attn_n = 1'b1;
    logic       seq_sel = 1'b0;
    logic       lp_req = 1'b0;
    logic       lp_sel = 1'b0;
    logic       seq_done = 1'b0;
    logic [2:0] mode;
    logic       out_of_idle;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    localparam int M_OFF = 0, M_IDLE = 1, M_DOZE = 2, M_HIB = 3, M_RX = 4, M_TX = 5;
    localparam int OP_RISE = 0, OP_FALL = 1, OP_DONE = 2, OP_LP = 3, OP_ATTN = 4;

    always #2 clk = ~clk;

    xcvr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .attn_n(attn_n),
        .seq_sel(seq_sel), .lp_req(lp_req), .lp_sel(lp_sel), .seq_done(seq_done),
        .mode(mode), .out_of_idle(out_of_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Checks mode and the out-of-idle flag (R9) together.
    task automatic chk_mode(input string req, input int exp);
        chk(req, int'(mode), exp);
        chk("R9", int'(out_of_idle), (exp != M_IDLE) ? 1 : 0);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected mode after one operation, from the requirements.
    function automatic int exp_next(input int cur, input int op, input bit sel, input bit lps);
        case (op)
            OP_RISE: return (cur == M_IDLE) ? (sel ? M_TX : M_RX) : cur;
            OP_FALL: return (cur == M_RX || cur == M_TX) ? M_IDLE : cur;
            OP_DONE: return (cur == M_RX || cur == M_TX) ? M_IDLE : cur;
            OP_LP:   return (cur == M_IDLE) ? (lps ? M_HIB : M_DOZE) : cur;
            OP_ATTN: return (cur == M_DOZE || cur == M_HIB) ? M_IDLE : cur;
            default: return cur;
        endcase
    endfunction

    // Applies one operation starting at a falling edge and lets it settle.
    task automatic apply_op(input int op);
        case (op)
            OP_RISE: begin run_en = 1'b1; edges(4); end
            OP_FALL: begin run_en = 1'b0; edges(4); end
            OP_DONE: begin seq_done = 1'b1; edges(1); seq_done = 1'b0; edges(2); end
            OP_LP:   begin lp_req = 1'b1; edges(1); lp_req = 1'b0; edges(2); end
            OP_ATTN: begin attn_n = 1'b0; edges(4); attn_n = 1'b1; edges(3); end
            default: edges(1);
        endcase
    endtask

    initial begin
        #(4 * 150000);
        if (!fin) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cur;
        void'($urandom(32'h1357_2468));
        // R1: reset holds Off even with pins active.
        run_en = 1'b1; lp_req = 1'b1;
        edges(4);
        chk_mode("R1", M_OFF);
        run_en = 1'b0; lp_req = 1'b0;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        chk_mode("R2", M_IDLE);
        edges(3);

        // R3: receive start, due on the third edge, not the second.
        seq_sel = 1'b0; run_en = 1'b1;
        edges(2);
        chk_mode("R3 early", M_IDLE);
        edges(1);
        chk_mode("R3", M_RX);
        // R6: low-power request ignored during a sequence.
        lp_req = 1'b1; edges(1); lp_req = 1'b0;
        chk_mode("R6 ignored", M_RX);
        // R8: wake pin has no effect during a sequence.
        apply_op(OP_ATTN);
        chk_mode("R8 ignored", M_RX);
        // R4: enable drop forces Idle on the third edge.
        run_en = 1'b0;
        edges(2);
        chk_mode("R4 early", M_RX);
        edges(1);
        chk_mode("R4", M_IDLE);

        // R3/R5: transmit start, done, no restart while enable stays high.
        seq_sel = 1'b1; apply_op(OP_RISE);
        chk_mode("R3 tx", M_TX);
        seq_done = 1'b1; edges(1); seq_done = 1'b0;
        chk_mode("R5", M_IDLE);
        edges(10);
        chk_mode("R5 hold", M_IDLE);
        apply_op(OP_FALL);
        seq_sel = 1'b0; apply_op(OP_RISE);
        chk_mode("R5 restart", M_RX);
        apply_op(OP_FALL);

        // R10: rise and low-power request meet on the same edge.
        seq_sel = 1'b1; run_en = 1'b1;
        edges(2);
        lp_req = 1'b1; lp_sel = 1'b0; edges(1); lp_req = 1'b0;
        chk_mode("R10", M_TX);
        apply_op(OP_FALL);

        // R6/R7/R8: doze, ignored rise, wake, no start while high.
        lp_sel = 1'b0; apply_op(OP_LP);
        chk_mode("R6 doze", M_DOZE);
        apply_op(OP_RISE);
        chk_mode("R7", M_DOZE);
        attn_n = 1'b0;
        edges(2);
        chk_mode("R8 early", M_DOZE);
        edges(1);
        chk_mode("R8", M_IDLE);
        attn_n = 1'b1;
        edges(8);
        chk_mode("R7 no start", M_IDLE);
        apply_op(OP_FALL);
        lp_sel = 1'b1; apply_op(OP_LP);
        chk_mode("R6 hib", M_HIB);
        apply_op(OP_ATTN);
        chk_mode("R8 hib", M_IDLE);
        apply_op(OP_ATTN);
        chk_mode("R8 idle", M_IDLE);

        // Random operation mix against the expected-mode function.
        cur = M_IDLE;
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 4));
            if (op == OP_RISE && run_en) op = OP_FALL;
            else if (op == OP_FALL && !run_en) op = OP_RISE;
            seq_sel = 1'($urandom_range(0, 1));
            lp_sel  = 1'($urandom_range(0, 1));
            cur = exp_next(cur, op, seq_sel, lp_sel);
            apply_op(op);
            chk_mode("R3-R8 random", cur);
        end

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule